// File: doc/BRIEF.md
# Buffered Once-Per-Second Time Update Sequencer

This block counts seconds, minutes and hours in binary. It divides a slow timebase enable into one update per second. Two copies of the time are kept. The internal copy advances at every update. The user copy is what software reads, and it is refreshed from the internal copy at each update unless software holds the freeze control. While freeze is held, the internal count keeps running, so no time is lost while software reads or writes the time.

A status bit, `uip`, rises a fixed number of timebase ticks before each transfer. Software that sees it low knows that the user copy will not change for at least that long. After each transfer an update-ended flag is set. Also at each transfer, the new time is compared against three alarm bytes, and an alarm flag is set when they match. Either flag can raise an interrupt request. Both flags stay set until software clears them.

To set the time, software raises freeze, writes the time bytes and then lowers freeze. The written values are loaded into the internal counters at that moment.

Top module: `rtl_upd_seq`

## Requirements
- R1: After reset, the user time bytes are zero, `uip`, `uf`, `af` and `irq` are low, and all three alarm bytes are zero.
- R2: A transfer happens every TICKS_PER_SEC asserted `tick_en` cycles. Each transfer adds one second to the internal time.
- R3: `uip` rises exactly LEAD_TICKS ticks before the transfer and falls in the clock cycle after the transfer.
- R4: `uf` is set at every transfer and stays set until `clr_flags` is pulsed; a set in the same cycle wins over the clear. `irq` is high whenever (`uf` and `uf_ie`) or (`af` and `af_ie`) holds.
- R5: In binary, seconds and minutes wrap from 59 to 0 with a carry, and hours wrap from 23 to 0.
- R6: While `freeze` is 1, the user copy does not follow transfers, but the internal time still advances. After `freeze` falls with no time writes made, the next transfer shows the advanced internal time.
- R7: A time write (`wr_sel` 0 = seconds, 1 = minutes, 2 = hours) is accepted only while `freeze` is 1 and appears in the user copy one cycle later. A time write made while `freeze` is 0 is ignored. If any time write was made during the freeze, the user copy is loaded into the internal time when `freeze` falls.
- R8: Alarm bytes are written at `wr_sel` 3 (seconds), 4 (minutes) and 5 (hours). At a transfer, `af` is set when every alarm byte either equals the new internal time byte or has bits 7:6 equal to 2'b11 (don't-care).
- R9: Transfers and `uf` setting continue while `freeze` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle timebase enable (32.768 kHz rate) |
| freeze | input | 1 | Holds the user copy and enables time writes |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 3 | Write target: 0 sec, 1 min, 2 hr, 3..5 alarm sec/min/hr |
| wr_data | input | 8 | Write data |
| clr_flags | input | 1 | Clears `uf` and `af` |
| uf_ie | input | 1 | Update-ended interrupt enable |
| af_ie | input | 1 | Alarm interrupt enable |
| usr_sec | output | 8 | User copy of seconds |
| usr_min | output | 8 | User copy of minutes |
| usr_hr | output | 8 | User copy of hours |
| uip | output | 1 | Update-in-progress status |
| uf | output | 1 | Update-ended flag |
| af | output | 1 | Alarm flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to create from the ports is a full midnight carry that begins from a time software loaded, because it needs a freeze, time writes and a release. The release must land in the middle of a second, away from a transfer, and the internal time must have moved on during the freeze. The stimulus raises freeze, writes 23:59:58 and lets one second pass with the user copy held. It then releases freeze right after a flag clear and watches the next two transfers: 23:59:59 and then 00:00:00. The second of these transfers also matches the zero alarm bytes left from reset.

// File: rtl/rtl_upd_pkg.sv
package rtl_upd_pkg;
    localparam int BYTE_W = 8;
    localparam int N_FIELDS = 3;
    localparam logic [BYTE_W-1:0] SEC_MAX = 8'd59;
    localparam logic [BYTE_W-1:0] MIN_MAX = 8'd59;
    localparam logic [BYTE_W-1:0] HR_MAX  = 8'd23;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t hr;
        byte_t min;
        byte_t sec;
    } tm_t;

    typedef enum logic [2:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HR   = 3'd2,
        SEL_ASEC = 3'd3,
        SEL_AMIN = 3'd4,
        SEL_AHR  = 3'd5
    } wsel_e;
endpackage

// File: rtl/rtl_upd_prescaler.sv
module rtl_upd_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    output logic lead_hit,
    output logic wrap
);
    localparam int CW = $clog2(TICKS_PER_SEC);
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);
    localparam logic [CW-1:0] LEAD_AT = CW'(TICKS_PER_SEC - LEAD_TICKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        lead_hit = tick_en && (cnt_q == LEAD_AT);
        wrap     = tick_en && (cnt_q == LAST);
        if (tick_en) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rtl_upd_timeadv.sv
module rtl_upd_timeadv
    import rtl_upd_pkg::*;
(
    input  tm_t cur,
    output tm_t nxt
);
    always_comb begin
        nxt = cur;
        if (cur.sec >= SEC_MAX) begin
            nxt.sec = '0;
            if (cur.min >= MIN_MAX) begin
                nxt.min = '0;
                nxt.hr  = (cur.hr >= HR_MAX) ? '0 : cur.hr + 1'b1;
            end else begin
                nxt.min = cur.min + 1'b1;
            end
        end else begin
            nxt.sec = cur.sec + 1'b1;
        end
    end
endmodule

// File: rtl/rtl_upd_alarm_cmp.sv
module rtl_upd_alarm_cmp
    import rtl_upd_pkg::*;
(
    input  byte_t alm [N_FIELDS],
    input  tm_t   now,
    output logic  match
);
    byte_t fld [N_FIELDS];
    logic [N_FIELDS-1:0] hit;

    assign fld[0] = now.sec;
    assign fld[1] = now.min;
    assign fld[2] = now.hr;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        assign hit[i] = (alm[i][BYTE_W-1 -: 2] == 2'b11) || (alm[i] == fld[i]);
    end

    assign match = &hit;
endmodule

// File: rtl/rtl_upd_seq.sv
module rtl_upd_seq
    import rtl_upd_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int LEAD_TICKS    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       freeze,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    input  logic       clr_flags,
    input  logic       uf_ie,
    input  logic       af_ie,
    output logic [7:0] usr_sec,
    output logic [7:0] usr_min,
    output logic [7:0] usr_hr,
    output logic       uip,
    output logic       uf,
    output logic       af,
    output logic       irq
);
    typedef struct packed {
        tm_t  itm;
        tm_t  utm;
        logic uip;
        logic uf;
        logic af;
        logic xfer;
        logic frz;
        logic dirty;
    } st_t;

    st_t   st_d, st_q;
    byte_t alm_d [N_FIELDS];
    byte_t alm_q [N_FIELDS];

    logic lead_hit, wrap, match, frz_fall;
    tm_t  base, nxt;

    rtl_upd_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .LEAD_TICKS   (LEAD_TICKS)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .lead_hit(lead_hit),
        .wrap    (wrap)
    );

    assign frz_fall = st_q.frz && !freeze;
    assign base     = (frz_fall && st_q.dirty) ? st_q.utm : st_q.itm;

    rtl_upd_timeadv u_adv (
        .cur(base),
        .nxt(nxt)
    );

    rtl_upd_alarm_cmp u_cmp (
        .alm  (alm_q),
        .now  (nxt),
        .match(match)
    );

    always_comb begin
        st_d  = st_q;
        alm_d = alm_q;
        st_d.frz  = freeze;
        st_d.xfer = wrap;
        if (st_q.xfer) st_d.uip = 1'b0;
        if (lead_hit)  st_d.uip = 1'b1;

        if (wr_en) begin
            case (wr_sel)
                SEL_SEC:  if (freeze) begin st_d.utm.sec = wr_data; st_d.dirty = 1'b1; end
                SEL_MIN:  if (freeze) begin st_d.utm.min = wr_data; st_d.dirty = 1'b1; end
                SEL_HR:   if (freeze) begin st_d.utm.hr  = wr_data; st_d.dirty = 1'b1; end
                SEL_ASEC: alm_d[0] = wr_data;
                SEL_AMIN: alm_d[1] = wr_data;
                SEL_AHR:  alm_d[2] = wr_data;
                default:  ;
            endcase
        end

        if (frz_fall) begin
            st_d.itm   = base;
            st_d.dirty = 1'b0;
        end

        if (clr_flags) begin
            st_d.uf = 1'b0;
            st_d.af = 1'b0;
        end

        if (wrap) begin
            st_d.itm = nxt;
            if (!freeze) st_d.utm = nxt;
            st_d.uf = 1'b1;
            if (match) st_d.af = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < N_FIELDS; i++) alm_q[i] <= '0;
        end else begin
            st_q  <= st_d;
            alm_q <= alm_d;
        end
    end

    assign usr_sec = st_q.utm.sec;
    assign usr_min = st_q.utm.min;
    assign usr_hr  = st_q.utm.hr;
    assign uip     = st_q.uip;
    assign uf      = st_q.uf;
    assign af      = st_q.af;
    assign irq     = (st_q.uf && uf_ie) || (st_q.af && af_ie);
endmodule

// File: rtl/rtl_upd_seq_chk.sv
module rtl_upd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       freeze,
    input logic       wr_en,
    input logic       clr_flags,
    input logic [7:0] usr_sec,
    input logic [7:0] usr_min,
    input logic [7:0] usr_hr,
    input logic       uip,
    input logic       uf,
    input logic       af
);
    // R3: a user copy change outside a freeze write is preceded by uip
    assert_uip_leads_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ({usr_hr, usr_min, usr_sec} != $past({usr_hr, usr_min, usr_sec}) && !$past(freeze))
        |-> $past(uip));

    // R3: uip falls only after the update-ended flag was raised
    assert_uip_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(uip) |-> (uf || $past(clr_flags)));

    // R4: uf rises only at the end of a uip window
    assert_uf_after_uip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(uf) |-> $past(uip));

    // R4: flags are sticky until cleared
    assert_uf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (uf && !clr_flags) |=> uf);

    assert_af_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (af && !clr_flags) |=> af);

    // R6: user copy holds while frozen and not written
    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(freeze) && !$past(wr_en)) |-> $stable({usr_hr, usr_min, usr_sec}));
endmodule

bind rtl_upd_seq rtl_upd_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .freeze   (freeze),
    .wr_en    (wr_en),
    .clr_flags(clr_flags),
    .usr_sec  (usr_sec),
    .usr_min  (usr_min),
    .usr_hr   (usr_hr),
    .uip      (uip),
    .uf       (uf),
    .af       (af)
);

// File: tb/rtl_upd_seq_tb_top.sv
module rtl_upd_seq_tb_top;
    localparam int TPS  = 64;
    localparam int LEAD = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       freeze = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       clr_flags = 1'b0;
    logic       uf_ie = 1'b1;
    logic       af_ie = 1'b1;
    logic [7:0] usr_sec, usr_min, usr_hr;
    logic       uip, uf, af, irq;

    always #2 clk = ~clk;

    rtl_upd_seq #(.TICKS_PER_SEC(TPS), .LEAD_TICKS(LEAD)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .clr_flags(clr_flags),
        .uf_ie(uf_ie), .af_ie(af_ie), .usr_sec(usr_sec), .usr_min(usr_min),
        .usr_hr(usr_hr), .uip(uip), .uf(uf), .af(af), .irq(irq)
    );

    typedef struct {
        int s; int m; int h; bit a; bit irq;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int seen = 0;
    bit done = 0;

    int is_ = 0, im = 0, ih = 0;
    int us = 0, um = 0, uh = 0;
    int al[3] = '{0, 0, 0};
    bit frz = 0, dirty = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit alarm_hit(int s, int m, int h);
        int t[3];
        t[0] = s; t[1] = m; t[2] = h;
        for (int i = 0; i < 3; i++)
            if (!(al[i] >= 192 || al[i] == t[i])) return 0;
        return 1;
    endfunction

    // Driver: one second of expected behaviour
    task automatic one_second();
        item_t it;
        int target;
        is_++;
        if (is_ >= 60) begin is_ = 0; im++; end
        if (im >= 60) begin im = 0; ih++; end
        if (ih >= 24) ih = 0;
        if (!frz) begin us = is_; um = im; uh = ih; end
        it.s = us; it.m = um; it.h = uh;
        it.a = alarm_hit(is_, im, ih);
        it.irq = uf_ie || (af_ie && it.a);
        q.push_back(it);
        target = seen + 1;
        wait (seen >= target);
        @(negedge clk) clr_flags = 1'b1;
        @(negedge clk) clr_flags = 1'b0;
    endtask

    task automatic wr(int sel, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
        if (sel >= 3) al[sel-3] = data;
        else if (frz) begin
            dirty = 1;
            if (sel == 0) us = data;
            else if (sel == 1) um = data;
            else uh = data;
        end
    endtask

    task automatic set_frz(bit v);
        @(negedge clk) freeze = v;
        if (frz && !v && dirty) begin
            is_ = us; im = um; ih = uh; dirty = 0;
        end
        frz = v;
    endtask

    // Monitor
    initial begin
        bit uip_p = 0, uf_p = 0, counting = 0, fall_chk = 0;
        int lead = 0;
        item_t it;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (fall_chk) begin
                    chk(uip == 1'b0, "R3", "uip low after transfer", int'(uip), 0);
                    fall_chk = 0;
                end
                if (uip && !uip_p) begin counting = 1; lead = 0; end
                else if (counting) lead++;
                if (uf && !uf_p) begin
                    chk(lead == LEAD, "R3", "uip lead cycles", lead, LEAD);
                    counting = 0;
                    fall_chk = 1;
                    if (q.size() == 0) begin
                        chk(0, "R2", "unexpected transfer", 1, 0);
                    end else begin
                        it = q.pop_front();
                        chk(int'(usr_sec) == it.s, "R2", "usr_sec", int'(usr_sec), it.s);
                        chk(int'(usr_min) == it.m, "R5", "usr_min", int'(usr_min), it.m);
                        chk(int'(usr_hr) == it.h, "R5", "usr_hr", int'(usr_hr), it.h);
                        chk(af == it.a, "R8", "af", int'(af), int'(it.a));
                        chk(irq == it.irq, "R4", "irq", int'(irq), int'(it.irq));
                    end
                    seen++;
                end
                uip_p = uip;
                uf_p = uf;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(usr_sec == 0 && usr_min == 0 && usr_hr == 0, "R1", "time zero",
            int'(usr_sec) + int'(usr_min) + int'(usr_hr), 0);
        chk(uip == 0 && uf == 0 && af == 0 && irq == 0, "R1", "flags zero",
            int'({uip, uf, af, irq}), 0);
        rst_n = 1'b1;

        // R2 normal counting
        repeat (3) one_second();

        // R4 sticky flag and irq before clearing
        begin
            item_t it;
            int target;
            is_++;
            us = is_;
            it.s = us; it.m = um; it.h = uh; it.a = alarm_hit(is_, im, ih); it.irq = 1;
            q.push_back(it);
            target = seen + 1;
            wait (seen >= target);
            repeat (5) @(negedge clk);
            chk(uf == 1 && irq == 1, "R4", "uf/irq held", int'({uf, irq}), 3);
            clr_flags = 1'b1;
            @(negedge clk) clr_flags = 1'b0;
            chk(uf == 0 && irq == 0, "R4", "cleared", int'({uf, irq}), 0);
        end

        // R7 write ignored while not frozen
        wr(0, 40);
        chk(int'(usr_sec) == us, "R7", "write ignored", int'(usr_sec), us);
        one_second();

        // R6/R9 freeze without writes
        set_frz(1);
        repeat (2) one_second();
        set_frz(0);
        one_second();

        // R7/R5 set time while frozen, then midnight rollover
        set_frz(1);
        wr(0, 58); wr(1, 59); wr(2, 23);
        chk(usr_sec == 58 && usr_min == 59 && usr_hr == 23, "R7", "written visible",
            int'(usr_sec), 58);
        one_second();
        set_frz(0);
        one_second();
        one_second();

        // R8 alarm with don't-care bytes, irq only from alarm
        uf_ie = 1'b0;
        wr(3, 2); wr(4, 8'hC0); wr(5, 8'hFF);
        one_second();
        one_second();
        // R8 mismatched minute: no alarm
        wr(3, 3); wr(4, 7);
        one_second();
        one_second();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule